// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests from a set of peripheral sources and presents one winner to the CPU. Each source owns an 8-bit control byte with three live fields: a pending flag, a mask flag and a 3-bit priority level. A rising edge on a source's request input sets its pending flag. The CPU reads and writes these bytes through a simple register port, either as a whole byte or one bit at a time.

Every cycle the block looks at all sources that are pending and unmasked. It selects the one with the numerically lowest level, so level 0 is the most urgent. When two sources share a level, the lower source index wins. The result is registered and appears as a valid flag plus the source index. When the CPU acknowledges a source, that source's pending flag is cleared. A masked source keeps its pending flag and competes for service as soon as its mask is cleared.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every control byte reads 0x47 (not pending, masked, level 7), and `irq_valid_o` is 0.
- R2: Control byte layout: bit 7 is the pending flag, bit 6 is the mask flag (1 blocks service), bits 2:0 are the level (0 is the highest, 7 the lowest). Bits 5:3 always read 0.
- R3: A byte write (`wr_en_i`=1, `wr_bit_i`=0) loads the pending flag, the mask flag and the level of source `wr_sel_i` from `wr_data_i` bits 7, 6 and 2:0.
- R4: A bit write (`wr_en_i`=1, `wr_bit_i`=1) sets bit `bit_idx_i` of source `wr_sel_i` to `bit_val_i` and leaves every other bit unchanged. A bit write to bit 3, 4 or 5 changes nothing.
- R5: A 0-to-1 transition on `req_i[i]` sets the pending flag of source i, whether or not the source is masked. A request held high does not set the flag again after it has been cleared.
- R6: `ack_i`=1 clears the pending flag of source `ack_idx_i`.
- R7: If a request edge on a source falls in the same cycle as an acknowledge or a write to that source, the pending flag ends up set.
- R8: The winner is the pending, unmasked source with the lowest level number. On equal levels the lowest index wins. Masked sources never win.
- R9: `irq_valid_o` and `irq_idx_o` are registered. They show the arbitration of the register state one clock earlier, and `irq_valid_o` is 0 when no source is pending and unmasked.
- R10: A pending request that was held back by its mask is presented once the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Peripheral request lines, edge sensitive |
| wr_en_i | input | 1 | Register write strobe |
| wr_bit_i | input | 1 | 1 selects a bit write, 0 selects a byte write |
| wr_sel_i | input | IDX_W | Source whose control byte is written |
| wr_data_i | input | 8 | Data for a byte write |
| bit_idx_i | input | 3 | Bit position for a bit write |
| bit_val_i | input | 1 | Value for a bit write |
| rd_sel_i | input | IDX_W | Source whose control byte is read |
| rd_data_o | output | 8 | Control byte of the source given by rd_sel_i (combinational) |
| ack_i | input | 1 | CPU acknowledge |
| ack_idx_i | input | IDX_W | Source being acknowledged |
| irq_valid_o | output | 1 | An unmasked pending request is presented |
| irq_idx_o | output | IDX_W | Index of the winning source |

## Verification
A request edge on a source can arrive in the same cycle as the CPU acknowledge of that source, or in the same cycle as a software write that clears its pending bit. The directed part of the bench drops a request line and raises it again in exactly the cycle that carries the acknowledge. It then judges by reading the byte back, and the flag must still be set. During the random phase, acknowledges usually target the index currently presented while request lines toggle freely. This produces many such collisions and also collisions of writes with edges. A bench model applies the write, then the acknowledge, then the edge, and predicts every cycle's output and readback.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int          PRIO_W    = 3;
  localparam int          FLAG_BIT  = 7;
  localparam int          MASK_BIT  = 6;
  localparam logic [7:0]  CTRL_RST  = 8'h47;

  typedef struct packed {
    logic              flag;
    logic              mask;
    logic [PRIO_W-1:0] prio;
  } ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
    return {c.flag, c.mask, 3'b000, c.prio};
  endfunction

  function automatic ctrl_t byte_to_ctrl(logic [7:0] b);
    ctrl_t c;
    c.flag = b[FLAG_BIT];
    c.mask = b[MASK_BIT];
    c.prio = b[PRIO_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
`timescale 1ns/1ps
module irq_edge_det #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] evt_o
);
  logic [N_SRC-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i;
  end

  assign evt_o = req_i & ~req_q;
endmodule

// File: rtl/irq_src_reg.sv
`timescale 1ns/1ps
module irq_src_reg
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_hit_i,
  input  logic       wr_bit_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] bit_idx_i,
  input  logic       bit_val_i,
  input  logic       ack_hit_i,
  input  logic       evt_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;

  // order: software write, then ack clear, then request edge (edge wins)
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_hit_i) begin
      if (wr_bit_i) begin
        case (bit_idx_i)
          3'd7:              ctrl_d.flag = bit_val_i;
          3'd6:              ctrl_d.mask = bit_val_i;
          3'd0, 3'd1, 3'd2:  ctrl_d.prio[bit_idx_i[1:0]] = bit_val_i;
          default:           ;
        endcase
      end else begin
        ctrl_d = byte_to_ctrl(wr_data_i);
      end
    end
    if (ack_hit_i) ctrl_d.flag = 1'b0;
    if (evt_i)     ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= byte_to_ctrl(CTRL_RST);
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             cand_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [PRIO_W-1:0] best_prio;

  // strict less-than keeps the lowest index on equal levels
  always_comb begin
    found_o   = 1'b0;
    idx_o     = '0;
    best_prio = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_i[i] && (!found_o || prio_i[i] < best_prio)) begin
        found_o   = 1'b1;
        idx_o     = IDX_W'(i);
        best_prio = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             wr_en_i,
  input  logic             wr_bit_i,
  input  logic [IDX_W-1:0] wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic [2:0]       bit_idx_i,
  input  logic             bit_val_i,
  input  logic [IDX_W-1:0] rd_sel_i,
  output logic [7:0]       rd_data_o,
  input  logic             ack_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o
);
  logic [N_SRC-1:0]             evt;
  logic [N_SRC-1:0]             flag_vec;
  logic [N_SRC-1:0]             mask_vec;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_vec;
  ctrl_t                        ctrl [N_SRC];
  logic                         win_found;
  logic [IDX_W-1:0]             win_idx;

  irq_edge_det #(.N_SRC(N_SRC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .evt_o (evt)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_src_reg u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_hit_i (wr_en_i && (wr_sel_i == IDX_W'(g))),
      .wr_bit_i (wr_bit_i),
      .wr_data_i(wr_data_i),
      .bit_idx_i(bit_idx_i),
      .bit_val_i(bit_val_i),
      .ack_hit_i(ack_i && (ack_idx_i == IDX_W'(g))),
      .evt_i    (evt[g]),
      .ctrl_o   (ctrl[g])
    );
    assign flag_vec[g] = ctrl[g].flag;
    assign mask_vec[g] = ctrl[g].mask;
    assign prio_vec[g] = ctrl[g].prio;
  end

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .cand_i (flag_vec & ~mask_vec),
    .prio_i (prio_vec),
    .found_o(win_found),
    .idx_o  (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_o <= 1'b0;
      irq_idx_o   <= '0;
    end else begin
      irq_valid_o <= win_found;
      irq_idx_o   <= win_idx;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < N_SRC; i++)
      if (rd_sel_i == IDX_W'(i)) rd_data_o = ctrl_to_byte(ctrl[i]);
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
`timescale 1ns/1ps
module irq_prio_ctrl_chk #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] evt_i,
  input logic [N_SRC-1:0] flag_i,
  input logic [N_SRC-1:0] mask_i,
  input logic             ack_i,
  input logic [IDX_W-1:0] ack_idx_i,
  input logic             irq_valid_i,
  input logic [IDX_W-1:0] irq_idx_i
);
  logic [N_SRC-1:0] cand, cand_q;
  assign cand = flag_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cand_q <= '0;
    else         cand_q <= cand;
  end

  p_evt_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_i & $past(evt_i)) == $past(evt_i)));

  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !evt_i[ack_idx_i]) |=> !flag_i[$past(ack_idx_i)]);

  p_ack_evt_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && evt_i[ack_idx_i]) |=> flag_i[$past(ack_idx_i)]);

  p_winner_unmasked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i |-> cand_q[irq_idx_i]);

  p_idle_no_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand == '0) |=> !irq_valid_i);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt),
  .flag_i     (flag_vec),
  .mask_i     (mask_vec),
  .ack_i      (ack_i),
  .ack_idx_i  (ack_idx_i),
  .irq_valid_i(irq_valid_o),
  .irq_idx_i  (irq_idx_o)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int LIMIT = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          wr_en = 1'b0, wr_bit = 1'b0, bit_val = 1'b0, ack = 1'b0;
  logic [IW-1:0] wr_sel = '0, rd_sel = '0, ack_idx = '0;
  logic [7:0]    wr_data = '0;
  logic [2:0]    bit_idx = '0;
  logic [7:0]    rd_data;
  logic          irq_valid;
  logic [IW-1:0] irq_idx;

  int n_tests = 0, n_fail = 0, cycles = 0;
  logic         m_flag [N];
  logic         m_mask [N];
  logic [2:0]   m_prio [N];
  logic [N-1:0] m_req_prev;
  logic         e_valid;
  logic [IW-1:0] e_idx;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N)) u_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .wr_en_i(wr_en), .wr_bit_i(wr_bit), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .bit_idx_i(bit_idx), .bit_val_i(bit_val),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .ack_i(ack), .ack_idx_i(ack_idx),
    .irq_valid_o(irq_valid), .irq_idx_o(irq_idx)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_byte(int i);
    return {m_flag[i], m_mask[i], 3'b000, m_prio[i]};
  endfunction

  task automatic m_arb(output logic v, output logic [IW-1:0] idx);
    logic [2:0] bp;
    v = 1'b0; idx = '0; bp = 3'd7;
    for (int i = 0; i < N; i++)
      if (m_flag[i] && !m_mask[i] && (!v || m_prio[i] < bp)) begin
        v = 1'b1; idx = IW'(i); bp = m_prio[i];
      end
  endtask

  task automatic m_update();
    for (int i = 0; i < N; i++) begin
      if (wr_en && wr_sel == IW'(i)) begin
        if (wr_bit) begin
          if (bit_idx == 3'd7) m_flag[i] = bit_val;
          else if (bit_idx == 3'd6) m_mask[i] = bit_val;
          else if (bit_idx <= 3'd2) m_prio[i][bit_idx[1:0]] = bit_val;
        end else begin
          m_flag[i] = wr_data[7]; m_mask[i] = wr_data[6]; m_prio[i] = wr_data[2:0];
        end
      end
      if (ack && ack_idx == IW'(i)) m_flag[i] = 1'b0;
      if (req[i] && !m_req_prev[i]) m_flag[i] = 1'b1;
    end
    m_req_prev = req;
  endtask

  // one clock: model output, model state, then compare registered outputs
  task automatic tick();
    @(posedge clk);
    m_arb(e_valid, e_idx);
    m_update();
    #1;
    chk("R9 valid", irq_valid, e_valid);
    if (e_valid) chk("R8 index", irq_idx, e_idx);
    wr_en = 1'b0; ack = 1'b0;
  endtask

  task automatic rdchk(int i, logic [7:0] exp, string tag);
    rd_sel = IW'(i);
    #0.1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wbyte(int s, logic [7:0] d);
    wr_en = 1'b1; wr_bit = 1'b0; wr_sel = IW'(s); wr_data = d; tick();
  endtask

  task automatic wbit(int s, int b, logic v);
    wr_en = 1'b1; wr_bit = 1'b1; wr_sel = IW'(s); bit_idx = 3'(b); bit_val = v; tick();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_flag[i] = 1'b0; m_mask[i] = 1'b1; m_prio[i] = 3'd7;
    end
    m_req_prev = '0;
    #9 rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 valid", irq_valid, 1'b0);
    for (int i = 0; i < N; i++) rdchk(i, 8'h47, "R1 reset byte");
    tick();
    // R3/R2: byte write, bits 5:3 read 0
    wbyte(2, 8'hFF);
    rdchk(2, 8'hC7, "R3 byte write / R2 zero bits");
    tick();
    chk("R8 masked never wins", irq_valid, 1'b0);
    // R5: edge sets flag on masked source
    req[5] = 1'b1; tick();
    rdchk(5, 8'hC7, "R5 edge sets masked flag");
    // R4: bit writes
    wbit(5, 6, 1'b0);
    rdchk(5, 8'h87, "R4 bit write mask");
    chk("R9 not yet valid one clock after unmask", irq_valid, 1'b0);
    tick();
    chk("R10 unmasked pending presented", {irq_valid, irq_idx}, {1'b1, 3'd5});
    wbit(5, 2, 1'b0);
    rdchk(5, 8'h83, "R4 bit write prio");
    wbit(5, 4, 1'b1);
    rdchk(5, 8'h83, "R4 reserved bit ignored");
    // R8: unmask src2 at level 7, src5 level 3 wins; then tie at level 3
    wbit(2, 6, 1'b0); tick();
    chk("R8 lower level wins", irq_idx, 3'd5);
    wbyte(1, 8'h83); tick();
    chk("R8 tie lowest index", irq_idx, 3'd1);
    // R6: ack clears
    ack = 1'b1; ack_idx = 3'd1; tick();
    rdchk(1, 8'h03, "R6 ack clears flag");
    tick();
    chk("R6 next winner", irq_idx, 3'd5);
    // R5: level held high does not re-set after ack
    ack = 1'b1; ack_idx = 3'd5; tick(); tick();
    rdchk(5, 8'h03, "R5 held level no re-set");
    // R7: edge and ack in same cycle
    req[5] = 1'b0; tick();
    req[5] = 1'b1; ack = 1'b1; ack_idx = 3'd5; tick();
    rdchk(5, 8'h83, "R7 edge beats ack");
    // R7: edge and clearing bit write in same cycle
    req[5] = 1'b0; tick();
    req[5] = 1'b1; wr_en = 1'b1; wr_bit = 1'b1; wr_sel = 3'd5; bit_idx = 3'd7; bit_val = 1'b0;
    tick();
    rdchk(5, 8'h83, "R7 edge beats write");
    // random phase
    for (int c = 0; c < 3000; c++) begin
      req = req ^ N'($urandom & $urandom);
      if ($urandom_range(3) == 0) begin
        wr_en = 1'b1; wr_bit = $urandom_range(1); wr_sel = IW'($urandom);
        wr_data = 8'($urandom); bit_idx = 3'($urandom); bit_val = $urandom_range(1);
      end
      if ($urandom_range(2) == 0) begin
        ack = 1'b1;
        ack_idx = ($urandom_range(3) != 0) ? irq_idx : IW'($urandom);
      end
      tick();
      begin
        int s = $urandom_range(N-1);
        rdchk(s, m_byte(s), "R2 readback");
      end
    end
    finish_run();
  end
endmodule